// File: doc/BRIEF.md
# I2C Slave Buffer Controller

This block is the byte-level transaction engine of an I2C target device. A separate bit engine samples the bus and hands it one-cycle strobes: an address byte has arrived, a data byte has arrived, the master wants the next read byte, or a stop was seen. For each strobe the controller returns an ACK/NAK decision, and on reads it also returns the byte to shift out. Both are registered and valid one cycle after the strobe.

The bus reaches a local RAM through a sub-address scheme. The first byte of a write transfer sets a stored offset. Later data bytes fill the RAM from that point on. A read transfer starts again at the stored offset, and that offset survives stop conditions. Reads can reach the whole RAM, but writes only reach its lower part, so the tail of the RAM is read-only from the bus. A flag bit in the address byte selects a second, read-only table instead of the RAM. The table has its own offset and counter. A sticky write-activity flag and a sticky read-activity flag record bus traffic, and a clear pulse from the host resets them.

Top module: `i2c_buf_slave`

## Requirements
- R1: The address byte is laid out as bit 0 = direction (1 = read), bits 6:1 = slave address, bit 7 = table select. If bits 6:1 differ from the own address, the byte is NAKed and the engine stays idle, so a following data byte is also NAKed. The own address is `own_addr` when DYN_ADDR=1 and FIXED_ADDR otherwise.
- R2: A matching write address is ACKed. The engine then waits for an offset byte and does not change the buffer.
- R3: An offset byte at or above the readable size (RD_SIZE, or TBL_SIZE for the table) is NAKed. A smaller offset is ACKed and loaded into both the stored offset and the running counter.
- R4: After the offset, each data byte whose counter is below WR_SIZE is stored at the counter and ACKed, the counter is incremented and the write flag is set. A byte at or above WR_SIZE is NAKed and not stored.
- R5: A matching read address is ACKed and returns the byte at the stored offset. The counter becomes offset+1.
- R6: Each further read request returns the byte at the counter while the counter is below the readable size, then increments the counter and sets the read flag.
- R7: A read request at or beyond the readable size returns 0xFF and leaves the counter unchanged.
- R8: When the table-select bit is set, the table is used, with its own offset, counter and size TBL_SIZE. Table entry i holds (29*i+7) mod 256. Data bytes written after a table offset are NAKed, and the table does not affect the RAM offset.
- R9: A stop returns the engine to idle with no response. Stored offsets are kept, so the next read starts at the last offset accepted.
- R10: Every address, data or read strobe produces `rsp_valid` for exactly the next cycle. Cycles with no such strobe produce no response.
- R11: The activity flags stay set until `flag_clr` is pulsed. The clear wins over a set in the same cycle.
- R12: Reset clears the RAM, the offsets, the counters and the flags, and leaves the engine idle with no response pending.
- R13: A data byte outside an offset or write phase is NAKed. A read request outside a read phase returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_addr | input | 6 | Run-time slave address (used when DYN_ADDR=1) |
| ev_addr | input | 1 | Strobe: address byte received in `rx_byte` |
| ev_data | input | 1 | Strobe: data byte received in `rx_byte` |
| ev_rdreq | input | 1 | Strobe: master requests the next read byte |
| ev_stop | input | 1 | Strobe: stop condition seen |
| rx_byte | input | 8 | Received byte for address or data strobes |
| flag_clr | input | 1 | Host pulse clearing both activity flags |
| rsp_valid | output | 1 | Response valid (one cycle after a strobe) |
| rsp_ack | output | 1 | 1 = ACK, 0 = NAK |
| rsp_tx | output | 1 | Response carries a byte to transmit |
| tx_byte | output | 8 | Byte to transmit |
| wr_act | output | 1 | Sticky write-activity flag |
| rd_act | output | 1 | Sticky read-activity flag |

## Verification
The bench builds the block with RD_SIZE=8, WR_SIZE=6, TBL_SIZE=5 and DYN_ADDR=1. With sizes this small, every offset value, including values past each size, can be tried. Every read burst can run past its end, and the read-only RAM tail is only two bytes. The run-time address makes it possible to sweep all 64 address values in both directions against one chosen own address.

// File: rtl/i2cbuf_pkg.sv
package i2cbuf_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAM_OFS,
        ST_RAM_WR,
        ST_RAM_RD,
        ST_TBL_OFS,
        ST_TBL_WR,
        ST_TBL_RD
    } st_e;

    typedef struct packed {
        logic       valid;
        logic       ack;
        logic       tx;
        logic [7:0] data;
    } rsp_t;

    localparam int unsigned RW_BIT  = 0;
    localparam int unsigned SEL_BIT = 7;
    localparam logic [7:0]  FILL    = 8'hFF;

    // Content of the read-only table, computed rather than listed
    function automatic logic [7:0] tbl_value(input int unsigned idx);
        return 8'((idx * 29 + 7) % 256);
    endfunction

    function automatic logic [5:0] addr_field(input logic [7:0] b);
        return b[6:1];
    endfunction

endpackage

// File: rtl/region_ptr.sv
module region_ptr #(
    parameter int unsigned SIZE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_val,
    input  logic       restart,
    input  logic       step,
    output logic [7:0] ofs,
    output logic [7:0] cnt
);
    localparam logic [7:0] SZ = 8'(SIZE);

    always_ff @(posedge clk) begin
        if (rst) begin
            ofs <= '0;
            cnt <= '0;
        end else if (load) begin
            ofs <= load_val;
            cnt <= load_val;
        end else if (restart) begin
            cnt <= ofs + 8'(step);
        end else if (step) begin
            cnt <= cnt + 8'd1;
        end
    end

    // R7: the running counter never passes the region size
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst) cnt <= SZ);
    // R3: only in-range offsets are ever stored
    p_ofs_bound_r3: assert property (@(posedge clk) disable iff (rst) ofs < SZ);

endmodule

// File: rtl/byte_ram.sv
module byte_ram
    import i2cbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic [7:0] waddr,
    input  logic [7:0] wdata,
    input  logic [7:0] raddr,
    output logic [7:0] rdata
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [7:0]  DP = 8'(DEPTH);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
        end else if (we && waddr < DP) begin
            mem[waddr[AW-1:0]] <= wdata;
        end
    end

    assign rdata = (raddr < DP) ? mem[raddr[AW-1:0]] : FILL;

endmodule

// File: rtl/tbl_rom.sv
module tbl_rom
    import i2cbuf_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic [7:0] raddr,
    output logic [7:0] rdata
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [7:0]  DP = 8'(DEPTH);

    logic [7:0] rom [DEPTH];

    for (genvar g = 0; g < int'(DEPTH); g++) begin : g_ent
        assign rom[g] = tbl_value(g);
    end

    assign rdata = (raddr < DP) ? rom[raddr[AW-1:0]] : FILL;

endmodule

// File: rtl/i2c_buf_slave.sv
module i2c_buf_slave
    import i2cbuf_pkg::*;
#(
    parameter int unsigned RD_SIZE    = 16,
    parameter int unsigned WR_SIZE    = 12,
    parameter int unsigned TBL_SIZE   = 8,
    parameter bit          TBL_EN     = 1'b1,
    parameter bit          DYN_ADDR   = 1'b0,
    parameter logic [5:0]  FIXED_ADDR = 6'h2A
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] own_addr,
    input  logic       ev_addr,
    input  logic       ev_data,
    input  logic       ev_rdreq,
    input  logic       ev_stop,
    input  logic [7:0] rx_byte,
    input  logic       flag_clr,
    output logic       rsp_valid,
    output logic       rsp_ack,
    output logic       rsp_tx,
    output logic [7:0] tx_byte,
    output logic       wr_act,
    output logic       rd_act
);
    localparam logic [7:0] RD_LIM  = 8'(RD_SIZE);
    localparam logic [7:0] WR_LIM  = 8'(WR_SIZE);
    localparam logic [7:0] TBL_LIM = 8'(TBL_SIZE);

    st_e        st, st_n;
    rsp_t       rsp_q, rsp_n;
    logic       set_wr, set_rd;

    logic       r_load, r_restart, r_step;
    logic       t_load, t_restart, t_step;
    logic [7:0] r_ofs, r_cnt, t_ofs, t_cnt;
    logic       ram_we;
    logic [7:0] ram_raddr, ram_rdata, tbl_raddr, tbl_rdata;

    logic [5:0] my_addr;
    logic       hit, sel_tbl, is_rd;

    assign my_addr = DYN_ADDR ? own_addr : FIXED_ADDR;
    assign hit     = (addr_field(rx_byte) == my_addr);
    assign sel_tbl = TBL_EN && rx_byte[SEL_BIT];
    assign is_rd   = rx_byte[RW_BIT];

    // On an address strobe the fetch comes from the stored offset
    assign ram_raddr = ev_addr ? r_ofs : r_cnt;
    assign tbl_raddr = ev_addr ? t_ofs : t_cnt;

    region_ptr #(.SIZE(RD_SIZE)) u_ram_ptr (
        .clk(clk), .rst(rst), .load(r_load), .load_val(rx_byte),
        .restart(r_restart), .step(r_step), .ofs(r_ofs), .cnt(r_cnt)
    );

    region_ptr #(.SIZE(TBL_SIZE)) u_tbl_ptr (
        .clk(clk), .rst(rst), .load(t_load), .load_val(rx_byte),
        .restart(t_restart), .step(t_step), .ofs(t_ofs), .cnt(t_cnt)
    );

    byte_ram #(.DEPTH(RD_SIZE)) u_ram (
        .clk(clk), .rst(rst), .we(ram_we), .waddr(r_cnt), .wdata(rx_byte),
        .raddr(ram_raddr), .rdata(ram_rdata)
    );

    if (TBL_EN) begin : g_tbl
        tbl_rom #(.DEPTH(TBL_SIZE)) u_tbl (.raddr(tbl_raddr), .rdata(tbl_rdata));
    end else begin : g_no_tbl
        assign tbl_rdata = FILL;
    end

    always_comb begin
        st_n      = st;
        rsp_n     = '{valid: 1'b0, ack: 1'b0, tx: 1'b0, data: FILL};
        set_wr    = 1'b0;
        set_rd    = 1'b0;
        ram_we    = 1'b0;
        r_load    = 1'b0; r_restart = 1'b0; r_step = 1'b0;
        t_load    = 1'b0; t_restart = 1'b0; t_step = 1'b0;

        if (ev_stop) begin
            st_n = ST_IDLE;
        end else if (ev_addr) begin
            rsp_n.valid = 1'b1;
            if (!hit) begin
                st_n = ST_IDLE;
            end else if (sel_tbl) begin
                rsp_n.ack = 1'b1;
                if (is_rd) begin
                    st_n       = ST_TBL_RD;
                    t_restart  = 1'b1;
                    t_step     = 1'b1;
                    rsp_n.tx   = 1'b1;
                    rsp_n.data = tbl_rdata;
                end else begin
                    st_n = ST_TBL_OFS;
                end
            end else begin
                rsp_n.ack = 1'b1;
                if (is_rd) begin
                    st_n       = ST_RAM_RD;
                    r_restart  = 1'b1;
                    r_step     = 1'b1;
                    rsp_n.tx   = 1'b1;
                    rsp_n.data = ram_rdata;
                end else begin
                    st_n = ST_RAM_OFS;
                end
            end
        end else if (ev_data) begin
            rsp_n.valid = 1'b1;
            unique case (st)
                ST_RAM_OFS: if (rx_byte < RD_LIM) begin
                    r_load    = 1'b1;
                    st_n      = ST_RAM_WR;
                    rsp_n.ack = 1'b1;
                end
                ST_RAM_WR: if (r_cnt < WR_LIM) begin
                    ram_we    = 1'b1;
                    r_step    = 1'b1;
                    set_wr    = 1'b1;
                    rsp_n.ack = 1'b1;
                end
                ST_TBL_OFS: if (rx_byte < TBL_LIM) begin
                    t_load    = 1'b1;
                    st_n      = ST_TBL_WR;
                    rsp_n.ack = 1'b1;
                end
                default: ;
            endcase
        end else if (ev_rdreq) begin
            rsp_n.valid = 1'b1;
            rsp_n.tx    = 1'b1;
            unique case (st)
                ST_RAM_RD: if (r_cnt < RD_LIM) begin
                    rsp_n.data = ram_rdata;
                    r_step     = 1'b1;
                    set_rd     = 1'b1;
                end
                ST_TBL_RD: if (t_cnt < TBL_LIM) begin
                    rsp_n.data = tbl_rdata;
                    t_step     = 1'b1;
                    set_rd     = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            rsp_q  <= '{valid: 1'b0, ack: 1'b0, tx: 1'b0, data: FILL};
            wr_act <= 1'b0;
            rd_act <= 1'b0;
        end else begin
            st    <= st_n;
            rsp_q <= rsp_n;
            if (flag_clr) begin
                wr_act <= 1'b0;
                rd_act <= 1'b0;
            end else begin
                wr_act <= wr_act | set_wr;
                rd_act <= rd_act | set_rd;
            end
        end
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_ack   = rsp_q.ack;
    assign rsp_tx    = rsp_q.tx;
    assign tx_byte   = rsp_q.data;

    // R9: stop always lands in idle
    p_stop_idle_r9: assert property (@(posedge clk) disable iff (rst)
        ev_stop |=> st == ST_IDLE);

    // R10: a strobe is answered in the next cycle, silence otherwise
    p_rsp_next_r10: assert property (@(posedge clk) disable iff (rst)
        (!ev_stop && (ev_addr || ev_data || ev_rdreq)) |=> rsp_valid);
    p_rsp_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (ev_stop || !(ev_addr || ev_data || ev_rdreq)) |=> !rsp_valid);

    // R1: foreign address is refused and leaves the engine idle
    p_foreign_nak_r1: assert property (@(posedge clk) disable iff (rst)
        (ev_addr && !ev_stop && addr_field(rx_byte) != my_addr)
        |=> (!rsp_ack && st == ST_IDLE));

    // R7: reading past the RAM end yields fill and holds the counter
    p_fill_end_r7: assert property (@(posedge clk) disable iff (rst)
        (ev_rdreq && !ev_stop && !ev_addr && !ev_data && st == ST_RAM_RD && r_cnt == RD_LIM)
        |=> (tx_byte == FILL && $stable(r_cnt)));

    // R8: writes into the table region are always refused
    p_tbl_ro_r8: assert property (@(posedge clk) disable iff (rst)
        (ev_data && !ev_stop && !ev_addr && st == ST_TBL_WR) |=> !rsp_ack);

    // R11: flags are sticky and the host clear wins
    p_wr_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_act && !flag_clr) |=> wr_act);
    p_clr_wins_r11: assert property (@(posedge clk) disable iff (rst)
        flag_clr |=> (!wr_act && !rd_act));

endmodule

// File: tb/sim_i2c_buf_slave.sv
module sim_i2c_buf_slave;
    localparam int CLK_PERIOD = 10;
    localparam int RD  = 8;
    localparam int WR  = 6;
    localparam int TS  = 5;
    localparam logic [5:0] OWN = 6'h15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ev_addr = 0, ev_data = 0, ev_rdreq = 0, ev_stop = 0, flag_clr = 0;
    logic [7:0] rx_byte = '0;
    logic rsp_valid, rsp_ack, rsp_tx, wr_act, rd_act;
    logic [7:0] tx_byte;

    int n_chk = 0, n_err = 0;
    bit done = 0;
    logic [7:0] ram_m [RD];
    int rofs_m = 0, tofs_m = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_buf_slave #(.RD_SIZE(RD), .WR_SIZE(WR), .TBL_SIZE(TS), .TBL_EN(1'b1),
                    .DYN_ADDR(1'b1), .FIXED_ADDR(6'h00)) u0 (
        .clk(clk), .rst(rst), .own_addr(OWN), .ev_addr(ev_addr), .ev_data(ev_data),
        .ev_rdreq(ev_rdreq), .ev_stop(ev_stop), .rx_byte(rx_byte), .flag_clr(flag_clr),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_tx(rsp_tx), .tx_byte(tx_byte),
        .wr_act(wr_act), .rd_act(rd_act)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    // kind: 0 addr, 1 data, 2 read request, 3 stop, 4 flag clear
    task automatic pulse(input int kind, input logic [7:0] b);
        @(negedge clk);
        rx_byte  = b;
        ev_addr  = (kind == 0);
        ev_data  = (kind == 1);
        ev_rdreq = (kind == 2);
        ev_stop  = (kind == 3);
        flag_clr = (kind == 4);
        @(negedge clk);
        ev_addr = 0; ev_data = 0; ev_rdreq = 0; ev_stop = 0; flag_clr = 0;
    endtask

    function automatic logic [7:0] abyte(input bit sel, input logic [5:0] a, input bit rd);
        return {sel, a, rd};
    endfunction

    function automatic int exp_byte(input bit sel, input int idx);
        if (sel) return (idx < TS) ? ((idx * 29 + 7) % 256) : 8'hFF;
        return (idx < RD) ? int'(ram_m[idx]) : 8'hFF;
    endfunction

    task automatic read_burst(input bit sel, input int n, input string tag);
        int idx = sel ? tofs_m : rofs_m;
        int size = sel ? TS : RD;
        pulse(0, abyte(sel, OWN, 1'b1));
        chk({tag, " R5 addr ack"}, rsp_ack, 1);
        chk({tag, " R5 first byte"}, tx_byte, exp_byte(sel, idx));
        idx++;
        for (int k = 0; k < n; k++) begin
            pulse(2, 8'h00);
            chk({tag, (idx < size) ? " R6 next byte" : " R7 fill"}, tx_byte, exp_byte(sel, idx));
            if (idx < size) idx++;
        end
        pulse(3, 8'h00);
    endtask

    task automatic set_ofs(input bit sel, input int o);
        pulse(0, abyte(sel, OWN, 1'b0));
        pulse(1, 8'(o));
        if (o < (sel ? TS : RD)) begin
            if (sel) tofs_m = o; else rofs_m = o;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < RD; i++) ram_m[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12 reset state
        chk("R12 rsp_valid", rsp_valid, 0);
        chk("R12 wr_act", wr_act, 0);
        chk("R12 rd_act", rd_act, 0);
        read_burst(1'b0, RD + 1, "R12 zero ram");

        // R10 response lasts exactly one cycle
        pulse(0, abyte(1'b0, OWN, 1'b0));
        chk("R10 valid after strobe", rsp_valid, 1);
        chk("R2 write addr ack", rsp_ack, 1);
        @(negedge clk);
        chk("R10 valid drops", rsp_valid, 0);
        pulse(3, 8'h00);
        chk("R9 stop gives no response", rsp_valid, 0);

        // R13 events in the wrong phase
        pulse(1, 8'h12);
        chk("R13 data in idle nak", rsp_ack, 0);
        pulse(2, 8'h00);
        chk("R13 read in idle tx", rsp_tx, 1);
        chk("R13 read in idle fill", tx_byte, 8'hFF);

        // R1 exhaustive address sweep
        for (int a = 0; a < 64; a++) begin
            for (int rw = 0; rw < 2; rw++) begin
                pulse(0, abyte(1'b0, 6'(a), rw[0]));
                chk("R1 addr compare", rsp_ack, (a == OWN) ? 1 : 0);
                if (a != OWN && rw == 0) begin
                    pulse(1, 8'h01);
                    chk("R1 stays idle", rsp_ack, 0);
                end
                pulse(3, 8'h00);
            end
        end

        // R2 write address alone touches nothing
        pulse(0, abyte(1'b0, OWN, 1'b0));
        pulse(3, 8'h00);
        chk("R2 no write flag", wr_act, 0);
        read_burst(1'b0, 2, "R2 buffer unchanged");

        // R3 offset range check, R9 persistence across stop
        for (int o = 0; o < RD + 2; o++) begin
            pulse(0, abyte(1'b0, OWN, 1'b0));
            pulse(1, 8'(o));
            chk("R3 offset range", rsp_ack, (o < RD) ? 1 : 0);
            if (o < RD) rofs_m = o;
            pulse(3, 8'h00);
        end
        read_burst(1'b0, 2, "R9 offset kept");

        // R4 writes bounded by the writable size
        pulse(4, 8'h00);
        set_ofs(1'b0, 0);
        for (int i = 0; i < RD; i++) begin
            pulse(1, 8'(8'hA0 + i));
            chk("R4 write ack", rsp_ack, (i < WR) ? 1 : 0);
            if (i < WR) ram_m[i] = 8'(8'hA0 + i);
        end
        chk("R4 write flag", wr_act, 1);
        pulse(3, 8'h00);
        set_ofs(1'b0, 4);
        for (int i = 0; i < 3; i++) begin
            pulse(1, 8'(8'h50 + i));
            chk("R4 tail write", rsp_ack, (4 + i < WR) ? 1 : 0);
            if (4 + i < WR) ram_m[4 + i] = 8'(8'h50 + i);
        end
        pulse(3, 8'h00);

        // R5 R6 R7 reads from every offset
        for (int o = 0; o < RD; o++) begin
            set_ofs(1'b0, o);
            pulse(3, 8'h00);
            pulse(4, 8'h00);
            read_burst(1'b0, RD - o + 2, "R6 sweep");
            chk("R6 read flag", rd_act, (o + 1 < RD) ? 1 : 0);
        end

        // R8 table region
        for (int o = 0; o < TS + 2; o++) begin
            pulse(0, abyte(1'b1, OWN, 1'b0));
            pulse(1, 8'(o));
            chk("R8 table offset range", rsp_ack, (o < TS) ? 1 : 0);
            if (o < TS) begin
                tofs_m = o;
                pulse(1, 8'h33);
                chk("R8 table write nak", rsp_ack, 0);
            end
            pulse(3, 8'h00);
            read_burst(1'b1, TS - tofs_m + 1, "R8 table read");
        end
        read_burst(1'b0, 1, "R8 ram offset untouched");

        // R11 sticky flags
        pulse(4, 8'h00);
        chk("R11 cleared wr", wr_act, 0);
        chk("R11 cleared rd", rd_act, 0);
        set_ofs(1'b0, 1);
        pulse(1, 8'h77);
        ram_m[1] = 8'h77;
        pulse(3, 8'h00);
        repeat (3) @(negedge clk);
        chk("R11 wr held", wr_act, 1);
        pulse(4, 8'h00);
        chk("R11 wr cleared", wr_act, 0);
        read_burst(1'b0, 1, "R11 stored byte");

        finish_run();
    end
endmodule